// File: doc/BRIEF.md
# Bidirectional Sync Pin Controller

This block controls the direction and content of two bidirectional sync pins on a video output port. With the master bit set, it drives both pins. In the video-refresh modes, pin 1 carries line timing and pin 2 carries frame timing. In the streaming and message modes, pin 1 carries the start-of-message pulse and pin 2 carries the end-of-message pulse. The timing and message pulses themselves come from elsewhere; this block only routes them to the pins, so the pads see clean registered levels.

With the master bit cleared, which is the reset state, both pins are released. The raw level on pin 2 passes through a synchronizer and an edge detector. A polarity bit selects whether a rising or a falling transition counts. Each selected transition produces a single-cycle frame-reference strobe for the rest of the output path.

Top module: `sync_port_ctl`

## Requirements
- R1: While rst_ni is low, and on the first sample after it rises, pad1_oe_o, pad2_oe_o, pad1_o, pad2_o and frame_ref_o are all 0.
- R2: A clock edge with master_i = 1 sets both pad1_oe_o and pad2_oe_o to 1 after that edge.
- R3: In video-refresh modes (mode_i = 2'b00 or 2'b01) with master_i = 1, pad1_o follows line_sync_i and pad2_o follows frame_sync_i, registered one clock edge later.
- R4: In streaming (mode_i = 2'b10) and message (mode_i = 2'b11) modes with master_i = 1, pad1_o follows msg_start_i and pad2_o follows msg_end_i, registered one clock edge later.
- R5: With master_i = 0, both output enables and both pad output values are 0 one clock edge later, whatever the mode and the timing inputs.
- R6: With master_i = 0 and edge_rise_i = 1, a low-to-high change on pad2_i makes frame_ref_o high for exactly the cycle after the third clock edge that follows the change (synchronizer depth plus one). A high-to-low change produces no strobe.
- R7: With master_i = 0 and edge_rise_i = 0, a high-to-low change on pad2_i gives the same single strobe. A low-to-high change produces no strobe.
- R8: frame_ref_o stays 0 while master_i = 1, whatever pad2_i does.
- R9: Toggling edge_rise_i while pad2_i is steady produces no strobe.
- R10: A pad2_i level held for many cycles after a selected transition produces only one strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1: drive both pins; 0: release both, pin 2 is an input |
| edge_rise_i | input | 1 | Pin 2 trigger edge in slave mode: 1 rising, 0 falling |
| mode_i | input | 2 | 00/01 video refresh, 10 streaming, 11 message |
| line_sync_i | input | 1 | Internal line timing |
| frame_sync_i | input | 1 | Internal frame timing |
| msg_start_i | input | 1 | Internal start-of-message pulse |
| msg_end_i | input | 1 | Internal end-of-message pulse |
| pad2_i | input | 1 | Raw pad level of pin 2 |
| pad1_oe_o | output | 1 | Pin 1 output enable |
| pad1_o | output | 1 | Pin 1 output value |
| pad2_oe_o | output | 1 | Pin 2 output enable |
| pad2_o | output | 1 | Pin 2 output value |
| frame_ref_o | output | 1 | Single-cycle frame-reference strobe |

## Verification
Pin direction and pin value respond one clock edge after their inputs. The bench drives every input on a falling clock edge and reads the result at the falling edge that follows the next rising edge. The frame-reference strobe is due at the third rising edge after pad2_i changes: two synchronizer stages plus the strobe register. The bench checks that it is low at the second sample, high at the third and low at the fourth. The cases that must produce no strobe (wrong edge, master mode, polarity toggle, held level) are checked by counting strobe cycles over a window long enough to cover that latency.

// File: rtl/sync_port_pkg.sv
package sync_port_pkg;
  typedef enum logic [1:0] {
    MODE_VID_A  = 2'b00,
    MODE_VID_B  = 2'b01,
    MODE_STREAM = 2'b10,
    MODE_MSG    = 2'b11
  } port_mode_e;

  function automatic logic is_video(input logic [1:0] m);
    return (m == MODE_VID_A) || (m == MODE_VID_B);
  endfunction
endpackage

// File: rtl/sync_port_sync.sv
module sync_port_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_LVL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sync_port_edge.sv
module sync_port_edge #(
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rise_sel_i,
  input  logic en_i,
  output logic strobe_o
);
  logic prev_q, strobe_q, hit;

  // only the currently chosen direction is tested, so a polarity flip on a
  // steady level cannot look like an edge
  always_comb begin
    if (rise_sel_i) hit = lvl_i & ~prev_q;
    else            hit = ~lvl_i & prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= RST_LVL;
      strobe_q <= 1'b0;
    end else begin
      prev_q   <= lvl_i;
      strobe_q <= hit & en_i;
    end
  end

  assign strobe_o = strobe_q;
endmodule

// File: rtl/sync_port_drv.sv
module sync_port_drv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drive_i,
  input  logic video_i,
  input  logic vid_val_i,
  input  logic msg_val_i,
  output logic oe_o,
  output logic val_o
);
  logic oe_q, val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= 1'b0;
      val_q <= 1'b0;
    end else begin
      oe_q  <= drive_i;
      val_q <= drive_i & (video_i ? vid_val_i : msg_val_i);
    end
  end

  assign oe_o  = oe_q;
  assign val_o = val_q;
endmodule

// File: rtl/sync_port_ctl.sv
module sync_port_ctl
  import sync_port_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic PAD_RST_LVL = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       master_i,
  input  logic       edge_rise_i,
  input  logic [1:0] mode_i,
  input  logic       line_sync_i,
  input  logic       frame_sync_i,
  input  logic       msg_start_i,
  input  logic       msg_end_i,
  input  logic       pad2_i,
  output logic       pad1_oe_o,
  output logic       pad1_o,
  output logic       pad2_oe_o,
  output logic       pad2_o,
  output logic       frame_ref_o
);
  localparam int NPINS = 2;

  logic             video;
  logic [NPINS-1:0] vid_val, msg_val, oe, val;
  logic             pad2_sync;

  assign video   = is_video(mode_i);
  assign vid_val = {frame_sync_i, line_sync_i};
  assign msg_val = {msg_end_i, msg_start_i};

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    sync_port_drv u_drv (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .drive_i   (master_i),
      .video_i   (video),
      .vid_val_i (vid_val[p]),
      .msg_val_i (msg_val[p]),
      .oe_o      (oe[p]),
      .val_o     (val[p])
    );
  end

  assign pad1_oe_o = oe[0];
  assign pad1_o    = val[0];
  assign pad2_oe_o = oe[1];
  assign pad2_o    = val[1];

  sync_port_sync #(.STAGES(SYNC_STAGES), .RST_LVL(PAD_RST_LVL)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad2_i),
    .q_o    (pad2_sync)
  );

  sync_port_edge #(.RST_LVL(PAD_RST_LVL)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (pad2_sync),
    .rise_sel_i (edge_rise_i),
    .en_i       (~master_i),
    .strobe_o   (frame_ref_o)
  );
endmodule

// File: rtl/sync_port_ctl_chk.sv
module sync_port_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       master_i,
  input logic [1:0] mode_i,
  input logic       line_sync_i,
  input logic       frame_sync_i,
  input logic       msg_start_i,
  input logic       msg_end_i,
  input logic       pad1_oe_o,
  input logic       pad1_o,
  input logic       pad2_oe_o,
  input logic       pad2_o,
  input logic       frame_ref_o
);
  // R2
  master_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |=> (pad1_oe_o && pad2_oe_o));

  // R3
  video_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !mode_i[1]) |=>
      (pad1_o == $past(line_sync_i) && pad2_o == $past(frame_sync_i)));

  // R4
  msg_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && mode_i[1]) |=>
      (pad1_o == $past(msg_start_i) && pad2_o == $past(msg_end_i)));

  // R5
  slave_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> (!pad1_oe_o && !pad2_oe_o && !pad1_o && !pad2_o));

  // R8
  no_master_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |=> !frame_ref_o);
endmodule

bind sync_port_ctl sync_port_ctl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .master_i     (master_i),
  .mode_i       (mode_i),
  .line_sync_i  (line_sync_i),
  .frame_sync_i (frame_sync_i),
  .msg_start_i  (msg_start_i),
  .msg_end_i    (msg_end_i),
  .pad1_oe_o    (pad1_oe_o),
  .pad1_o       (pad1_o),
  .pad2_oe_o    (pad2_oe_o),
  .pad2_o       (pad2_o),
  .frame_ref_o  (frame_ref_o)
);

// File: tb/sync_port_ctl_tb.sv
module sync_port_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       master, rise;
  logic [1:0] mode;
  logic       line_s, frame_s, m_start, m_end, pad2;
  logic       p1_oe, p1, p2_oe, p2, fref;
  int         checks = 0, fails = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  sync_port_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master), .edge_rise_i(rise),
    .mode_i(mode), .line_sync_i(line_s), .frame_sync_i(frame_s),
    .msg_start_i(m_start), .msg_end_i(m_end), .pad2_i(pad2),
    .pad1_oe_o(p1_oe), .pad1_o(p1), .pad2_oe_o(p2_oe), .pad2_o(p2),
    .frame_ref_o(fref)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pins();
    return {p1_oe, p1, p2_oe, p2};
  endfunction

  task automatic count_strobes(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fref) cnt++;
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; master = 0; rise = 0; mode = 2'b00;
    line_s = 0; frame_s = 0; m_start = 0; m_end = 0; pad2 = 0;
    repeat (3) @(negedge clk);
    chk("R1 pins in reset", pins(), 0);
    chk("R1 strobe in reset", fref, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 pins after reset", pins(), 0);
    chk("R1 strobe after reset", fref, 0);
  endtask

  task automatic t_master_video();
    master = 1; mode = 2'b00; line_s = 1; frame_s = 0;
    @(negedge clk);
    chk("R2 oe master", {p1_oe, p2_oe}, 3);
    chk("R3 video A line/frame", {p1, p2}, 2);
    mode = 2'b01; line_s = 0; frame_s = 1; m_start = 1; m_end = 0;
    @(negedge clk);
    chk("R3 video B line/frame", {p1, p2}, 1);
  endtask

  task automatic t_master_data();
    mode = 2'b10; line_s = 1; frame_s = 0; m_start = 0; m_end = 1;
    @(negedge clk);
    chk("R4 stream start/end", {p1, p2}, 1);
    mode = 2'b11; m_start = 1; m_end = 0;
    @(negedge clk);
    chk("R4 message start/end", {p1, p2}, 2);
    chk("R2 oe message", {p1_oe, p2_oe}, 3);
  endtask

  task automatic t_master_no_strobe();
    int cnt;
    pad2 = 1; rise = 1;
    count_strobes(3, cnt);
    pad2 = 0; rise = 0;
    count_strobes(5, cnt);
    chk("R8 no strobe in master", cnt, 0);
  endtask

  task automatic t_slave();
    master = 0; mode = 2'b11; line_s = 1; frame_s = 1; m_start = 1; m_end = 1;
    @(negedge clk);
    chk("R5 slave release msg", pins(), 0);
    mode = 2'b00;
    @(negedge clk);
    chk("R5 slave release video", pins(), 0);
  endtask

  // pad change at a negedge; strobe due after the 3rd following posedge
  task automatic edge_expect(input string req, input logic lvl, input int exp);
    pad2 = lvl;
    repeat (2) @(negedge clk);
    chk({req, " early"}, fref, 0);
    @(negedge clk);
    chk({req, " due"}, fref, exp);
    @(negedge clk);
    chk({req, " after"}, fref, 0);
  endtask

  task automatic t_rise();
    rise = 1;
    edge_expect("R6 rising", 1'b1, 1);
    edge_expect("R6 falling ignored", 1'b0, 0);
  endtask

  task automatic t_fall();
    rise = 0;
    edge_expect("R7 rising ignored", 1'b1, 0);
    edge_expect("R7 falling", 1'b0, 1);
  endtask

  task automatic t_pol_switch();
    int cnt;
    pad2 = 1;
    repeat (5) @(negedge clk);
    rise = 1;
    count_strobes(4, cnt);
    rise = 0;
    count_strobes(4, cnt);
    rise = 1;
    count_strobes(5, cnt);
    chk("R9 polarity toggle steady high", cnt, 0);
    pad2 = 0;
    rise = 0;
    count_strobes(5, cnt);
    chk("R9 falling after toggles", cnt, 1);
    rise = 1;
    count_strobes(5, cnt);
    chk("R9 polarity toggle steady low", cnt, 0);
  endtask

  task automatic t_single();
    int cnt;
    rise = 1; pad2 = 1;
    count_strobes(20, cnt);
    chk("R10 held level one strobe", cnt, 1);
  endtask

  initial begin
    t_reset();
    t_master_video();
    t_master_data();
    t_master_no_strobe();
    t_slave();
    t_rise();
    t_fall();
    t_pol_switch();
    t_single();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule